// File: doc/BRIEF.md
# Link-Layer Wake Request Generator

This block sits inside the physical layer of a serial bus. It decides when the physical layer has to wake the link-layer controller attached to it, and it produces the wake waveform.

A wake can come from two sources:
- a link-on packet addressed to this node, which is held in a sticky pending flag;
- a live interrupt condition, which is re-evaluated every cycle.

A wake can start only while the link is inactive. Once started, it lasts until the link reports itself active again. A bus reset cancels a wake unless an interrupt condition is present at that moment.

While the wake is active, the output is a square wave. It is high for `HALF_CYCLES` clocks and then low for `HALF_CYCLES` clocks. At all other times the output is low. While hardware reset is asserted, the output enable is low so that the pin floats.

Top module: `linkon_wake`

## Requirements
- R1: While `rst_n` is low, `wake_oe` is 0 and `wake_o` is 0. When `rst_n` is high, `wake_oe` is 1.
- R2: The link counts as inactive when `lps_on` is 0 or `lctrl_bit` is 0. With no pending packet and no interrupt request, `wake_o` stays 0.
- R3: While the wake is active, `wake_o` repeats a pattern of `HALF_CYCLES` cycles at 1 followed by `HALF_CYCLES` cycles at 0. With the default of 4 this gives a period of 8.
- R4: The interrupt request is `int_port_evt | (resume_ie & (int_cfg_tmo | int_cbl_pwr | int_state_tmo))`. When this request is present while the link is inactive, the wake becomes active at the next edge.
- R5: A `lnkon_pkt` strobe while the link is inactive sets the pending flag at the next edge. The pending flag activates the wake one edge after that.
- R6: When both `lps_on` and `lctrl_bit` are 1, the wake and the pending flag clear at the next edge, and `wake_o` is 0 from then on.
- R7: An active wake persists after every request term has gone away, as long as the link stays inactive and no bus reset arrives.
- R8: A `lnkon_pkt` strobe that arrives while the link is active is ignored. A later transition of the link to inactive does not start a wake.
- R9: A `bus_rst` strobe clears the pending flag. It also clears the wake unless the interrupt request is present in the same cycle. A `bus_rst` and a `lnkon_pkt` in the same cycle leave the pending flag clear.
- R10: If an interrupt request exists while the link is active, the wake starts at the first edge at which the link is inactive.
- R11: When the wake goes from inactive to active, the first cycle of `wake_o` is 1, which is the start of the high half of the pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low hardware reset |
| lps_on | input | 1 | Link power status (1 = powered) |
| lctrl_bit | input | 1 | Link-control register bit |
| lnkon_pkt | input | 1 | One-cycle strobe: link-on packet for this node received |
| int_port_evt | input | 1 | Port-event interrupt bit |
| int_cfg_tmo | input | 1 | Configuration-timeout interrupt bit |
| int_cbl_pwr | input | 1 | Cable-power-status interrupt bit |
| int_state_tmo | input | 1 | State-timeout interrupt bit |
| resume_ie | input | 1 | Resuming-port interrupt enable |
| bus_rst | input | 1 | One-cycle bus-reset strobe |
| wake_o | output | 1 | Wake square wave |
| wake_oe | output | 1 | Output enable for the wake pin |

## Verification
The bench builds the block with the default `HALF_CYCLES` of 4. This keeps the full 8-cycle pattern short enough that a single scenario covers several periods, including the wrap of the phase counter. Because of that, any error in the width or position of either half of the pattern appears on the per-cycle comparison against the behavioural model. The scenarios also combine bus resets with the interrupt request and the packet strobe, because that combination is the one that separates the two request sources.

// File: rtl/linkon_wake.sv
module linkon_wake #(
  parameter int HALF_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lps_on,
  input  logic lctrl_bit,
  input  logic lnkon_pkt,
  input  logic int_port_evt,
  input  logic int_cfg_tmo,
  input  logic int_cbl_pwr,
  input  logic int_state_tmo,
  input  logic resume_ie,
  input  logic bus_rst,
  output logic wake_o,
  output logic wake_oe
);
  localparam int PERIOD = 2 * HALF_CYCLES;
  localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;

  logic          link_idle;
  logic          irq_req;
  logic          pkt_pend;
  logic          wake_on;
  logic [CW-1:0] phase;

  assign link_idle = !(lps_on && lctrl_bit);
  assign irq_req   = int_port_evt |
                     (resume_ie & (int_cfg_tmo | int_cbl_pwr | int_state_tmo));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkt_pend <= 1'b0;
    end else if (!link_idle || bus_rst) begin
      pkt_pend <= 1'b0;
    end else if (lnkon_pkt) begin
      pkt_pend <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_on <= 1'b0;
    end else if (!link_idle) begin
      wake_on <= 1'b0;
    end else if (bus_rst) begin
      wake_on <= irq_req;
    end else if (pkt_pend || irq_req) begin
      wake_on <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (!wake_on) begin
      phase <= '0;
    end else if (phase == CW'(PERIOD - 1)) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  assign wake_o  = wake_on && (phase < CW'(HALF_CYCLES));
  assign wake_oe = rst_n;
endmodule

module linkon_wake_chk #(
  parameter int HALF_CYCLES = 4
) (
  input logic clk,
  input logic rst_n,
  input logic lps_on,
  input logic lctrl_bit,
  input logic int_port_evt,
  input logic int_cfg_tmo,
  input logic int_cbl_pwr,
  input logic int_state_tmo,
  input logic resume_ie,
  input logic bus_rst,
  input logic wake_on,
  input logic wake_o,
  input logic wake_oe
);
  localparam int RW = $clog2(HALF_CYCLES + 2) + 1;
  logic [RW-1:0] hi_run;
  logic          irq_c;
  logic          idle_c;

  assign irq_c  = int_port_evt | (resume_ie & (int_cfg_tmo | int_cbl_pwr | int_state_tmo));
  assign idle_c = !(lps_on && lctrl_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_run <= '0;
    else if (wake_o) hi_run <= hi_run + 1'b1;
    else hi_run <= '0;
  end

  always_comb begin
    if (!rst_n) begin
      a_r1_oe_low_in_reset: assert (!wake_oe);
    end
  end

  a_r3_high_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    hi_run <= RW'(HALF_CYCLES));

  a_r4_irq_starts_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_c && idle_c) |=> wake_on);

  a_r6_active_link_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_c) |=> !wake_o);

  a_r7_wake_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_on && idle_c && !bus_rst) |=> wake_on);

  a_r9_bus_reset_cancels: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rst && !irq_c) |=> !wake_on);

  a_r11_first_cycle_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_on) |-> wake_o);
endmodule

bind linkon_wake linkon_wake_chk #(.HALF_CYCLES(HALF_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .lps_on(lps_on), .lctrl_bit(lctrl_bit),
  .int_port_evt(int_port_evt), .int_cfg_tmo(int_cfg_tmo),
  .int_cbl_pwr(int_cbl_pwr), .int_state_tmo(int_state_tmo),
  .resume_ie(resume_ie), .bus_rst(bus_rst), .wake_on(wake_on),
  .wake_o(wake_o), .wake_oe(wake_oe)
);

// File: tb/linkon_wake_bench.sv
module linkon_wake_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lps_on = 1'b0, lctrl_bit = 1'b0, lnkon_pkt = 1'b0;
  logic int_port_evt = 1'b0, int_cfg_tmo = 1'b0, int_cbl_pwr = 1'b0, int_state_tmo = 1'b0;
  logic resume_ie = 1'b0, bus_rst = 1'b0;
  logic wake_o, wake_oe;

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";

  bit m_pend = 1'b0;
  bit m_on = 1'b0;
  int m_phase = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  linkon_wake #(.HALF_CYCLES(HALF)) u_linkon_wake (
    .clk(clk), .rst_n(rst_n), .lps_on(lps_on), .lctrl_bit(lctrl_bit),
    .lnkon_pkt(lnkon_pkt), .int_port_evt(int_port_evt), .int_cfg_tmo(int_cfg_tmo),
    .int_cbl_pwr(int_cbl_pwr), .int_state_tmo(int_state_tmo), .resume_ie(resume_ie),
    .bus_rst(bus_rst), .wake_o(wake_o), .wake_oe(wake_oe)
  );

  function automatic bit m_irq();
    return int_port_evt || (resume_ie && (int_cfg_tmo || int_cbl_pwr || int_state_tmo));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend <= 1'b0; m_on <= 1'b0; m_phase <= 0;
    end else begin
      bit idle;
      idle = !(lps_on && lctrl_bit);
      m_phase <= m_on ? (m_phase + 1) % (2 * HALF) : 0;
      if (!idle) begin
        m_pend <= 1'b0; m_on <= 1'b0;
      end else begin
        if (bus_rst) m_pend <= 1'b0;
        else if (lnkon_pkt) m_pend <= 1'b1;
        if (bus_rst) m_on <= m_irq();
        else if (m_pend || m_irq()) m_on <= 1'b1;
      end
    end
  end

  task automatic compare();
    bit exp_w, exp_oe;
    exp_oe = rst_n;
    exp_w = rst_n && m_on && (m_phase < HALF);
    checks++;
    if (wake_o !== exp_w || wake_oe !== exp_oe) begin
      fails++;
      $display("FAIL %s: wake_o=%b wake_oe=%b expected wake_o=%b wake_oe=%b at %0t",
               cur_req, wake_o, wake_oe, exp_w, exp_oe, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      lnkon_pkt = 1'b0;
      bus_rst = 1'b0;
    end
  endtask

  task automatic link(input bit on);
    lps_on = on; lctrl_bit = on;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    cur_req = "R1"; cyc(3);
    rst_n = 1'b1;
    cur_req = "R2"; link(1'b1); cyc(4);
    link(1'b0); cyc(6);
    lps_on = 1'b1; cyc(3);
    lps_on = 1'b0; lctrl_bit = 1'b1; cyc(3);
    lctrl_bit = 1'b0;

    cur_req = "R5"; lnkon_pkt = 1'b1; cyc(3);
    cur_req = "R3"; cyc(24);
    cur_req = "R6"; link(1'b1); cyc(6);

    cur_req = "R8"; lnkon_pkt = 1'b1; cyc(3);
    link(1'b0); cyc(10);

    cur_req = "R4"; int_port_evt = 1'b1; cyc(3);
    cur_req = "R7"; int_port_evt = 1'b0; cyc(13);
    cur_req = "R9"; bus_rst = 1'b1; cyc(6);

    cur_req = "R4"; int_cfg_tmo = 1'b1; cyc(5);
    resume_ie = 1'b1; cyc(7);
    cur_req = "R9"; bus_rst = 1'b1; cyc(6);
    int_cfg_tmo = 1'b0; int_cbl_pwr = 1'b1; cyc(3);
    int_cbl_pwr = 1'b0; int_state_tmo = 1'b1; cyc(3);
    int_state_tmo = 1'b0; bus_rst = 1'b1; cyc(5);

    cur_req = "R9"; lnkon_pkt = 1'b1; cyc(1);
    bus_rst = 1'b1; cyc(6);
    lnkon_pkt = 1'b1; bus_rst = 1'b1; cyc(6);
    lnkon_pkt = 1'b1; cyc(5);
    bus_rst = 1'b1; cyc(5);

    cur_req = "R10"; link(1'b1); cyc(2);
    int_state_tmo = 1'b1; cyc(5);
    cur_req = "R11"; link(1'b0); cyc(10);
    int_state_tmo = 1'b0; resume_ie = 1'b0;
    cur_req = "R6"; lctrl_bit = 1'b1; lps_on = 1'b1; cyc(4);

    cur_req = "R1"; link(1'b0); int_port_evt = 1'b1; cyc(3);
    rst_n = 1'b0; #1; compare(); cyc(3);
    rst_n = 1'b1; cyc(6);
    int_port_evt = 1'b0; link(1'b1); cyc(3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule